// File: doc/BRIEF.md
# Register Bank Test Access Controller

This block gives a test port into a bank of storage cells, where each cell holds a first-rank register and a second-rank register. In normal use both registers of every cell capture their own data inputs on the system clock. A test engineer can force a known state into the bank instead. In preload mode, each rising edge of a test strobe writes twelve registers at once from a twelve-bit pin bus. Two select inputs pick the group: one picks the register rank and the other picks even-numbered or odd-numbered cells.

In observe mode, the outputs show the second-rank registers in place of the normal output data. These registers are otherwise buried inside the cells. The per-output enables still gate each output. A security input blocks both test modes, and with it set the block behaves as in normal use. All state is in the system clock domain. The test strobe is sampled and edge-detected, so one strobe pulse loads its group exactly once.

Top module: `reg_test_access`

## Requirements
- R1: While `rst` is high at a clock edge, every first-rank and second-rank register is cleared to 0 by that edge.
- R2: When no preload load takes place at an edge and `cap_en` is high, every cell's first-rank register takes `d_rank1` and its second-rank register takes `d_rank2`. When `cap_en` is low, the registers hold.
- R3: A preload load occurs at the clock edge where `tst_stb` is high and was low at the previous edge, while `pl_mode` is high and `lock` is low. `rank_sel`=0 picks the first rank and `rank_sel`=1 picks the second. `odd_sel`=0 picks even cells and `odd_sel`=1 picks odd cells.
- R4: On a preload load, bit i of `pl_data` goes to cell 2*i+`odd_sel`.
- R5: A loaded register takes exactly the level of its `pl_data` bit. `cap_en`, `d_rank1` and `d_rank2` have no effect on it.
- R6: At an edge with a preload load, every register outside the selected group keeps its value, even with `cap_en` high.
- R7: A strobe held high for several clocks gives only one load. A strobe edge seen while `pl_mode` is low loads nothing.
- R8: Each output bit `pin_q[c]` is 0 while `pin_oe[c]` is low. When `pin_oe[c]` is high, `pin_q[c]` shows the cell's second-rank register if `obs_mode` is high and `lock` is low, and shows `out_d[c]` otherwise.
- R9: With `lock` high, preload loads and observe routing are both inhibited, and normal capture and output continue.
- R10: With `pl_mode` and `obs_mode` both high, a strobe edge still loads its group, and the outputs show the second-rank registers, including the newly loaded values from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Normal capture enable for all registers |
| d_rank1 | input | 24 | Normal data for first-rank registers, one bit per cell |
| d_rank2 | input | 24 | Normal data for second-rank registers, one bit per cell |
| out_d | input | 24 | Normal output data |
| pin_oe | input | 24 | Per-output enable |
| pl_mode | input | 1 | Preload mode enable |
| obs_mode | input | 1 | Second-rank observe mode enable |
| lock | input | 1 | Security bit, inhibits both test modes |
| tst_stb | input | 1 | Preload strobe, acts on its rising edge |
| rank_sel | input | 1 | 0 selects the first rank, 1 selects the second |
| odd_sel | input | 1 | 0 selects even cells, 1 selects odd cells |
| pl_data | input | 12 | Preload data, bit i maps to cell 2*i+odd_sel |
| rank1_q | output | 24 | First-rank register contents |
| rank2_q | output | 24 | Second-rank register contents |
| pin_q | output | 24 | Gated output data |

## Verification
The hardest case to reach from the ports is a preload edge that coincides with active normal capture, where the unselected registers would change if the hold rule were broken. The stimulus places fresh random `d_rank1`/`d_rank2` data with `cap_en` high on every strobe edge, in all four rank and parity groups. It then holds the strobe high for several clocks to expose any repeated load. A random phase mixes strobe toggles with mode, lock and select changes, so that edges also fall inside lock windows and at mode switches. A behavioural model checks this phase on every clock.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int CELL_N = 24;
    localparam int GRP_W  = CELL_N / 2;

    typedef enum logic {
        RANK_ONE = 1'b0,
        RANK_TWO = 1'b1
    } rank_e;

    typedef enum logic {
        CELLS_EVEN = 1'b0,
        CELLS_ODD  = 1'b1
    } parity_e;

    typedef struct packed {
        rank_e   rank;
        parity_e parity;
    } group_t;

    typedef struct packed {
        logic   load;
        logic   capture;
        group_t grp;
    } bank_ctl_t;

    // Mask of cells that belong to one parity group.
    function automatic logic [CELL_N-1:0] parity_mask(parity_e p);
        logic [CELL_N-1:0] m;
        for (int c = 0; c < CELL_N; c++) begin
            m[c] = ((c % 2) == int'(p));
        end
        return m;
    endfunction

    // Place group data onto the cells of one parity.
    function automatic logic [CELL_N-1:0] spread(logic [GRP_W-1:0] d, parity_e p);
        logic [CELL_N-1:0] v;
        v = '0;
        for (int i = 0; i < GRP_W; i++) begin
            v[2*i + int'(p)] = d[i];
        end
        return v;
    endfunction

    // Pull the cells of one parity back into group order.
    function automatic logic [GRP_W-1:0] gather(logic [CELL_N-1:0] v, parity_e p);
        logic [GRP_W-1:0] d;
        for (int i = 0; i < GRP_W; i++) begin
            d[i] = v[2*i + int'(p)];
        end
        return d;
    endfunction

endpackage

// File: rtl/tap_mode_dec.sv
module tap_mode_dec
    import tap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cap_en,
    input  logic      pl_mode,
    input  logic      obs_mode,
    input  logic      lock,
    input  logic      tst_stb,
    input  logic      rank_sel,
    input  logic      odd_sel,
    output bank_ctl_t ctl,
    output logic      obs_on
);

    logic stb_q;
    logic pl_on;
    logic stb_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= 1'b0;
        end else begin
            stb_q <= tst_stb;
        end
    end

    always_comb begin
        pl_on      = pl_mode && !lock;
        obs_on     = obs_mode && !lock;
        stb_rise   = tst_stb && !stb_q;
        ctl.load   = pl_on && stb_rise;
        ctl.capture = cap_en;
        ctl.grp.rank   = rank_e'(rank_sel);
        ctl.grp.parity = parity_e'(odd_sel);
    end

    // R7: a strobe held high cannot load on two consecutive edges
    a_r7_single_load: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> !ctl.load);

    // R9: lock blocks any load
    a_r9_lock_no_load: assert property (@(posedge clk) disable iff (rst)
        lock |-> !ctl.load);

endmodule

// File: rtl/tap_cell_bank.sv
module tap_cell_bank
    import tap_pkg::*;
#(
    parameter int NCELL = tap_pkg::CELL_N,
    localparam int GW   = NCELL / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_ctl_t        ctl,
    input  logic [NCELL-1:0] d_rank1,
    input  logic [NCELL-1:0] d_rank2,
    input  logic [GW-1:0]    pl_data,
    output logic [NCELL-1:0] rank1_q,
    output logic [NCELL-1:0] rank2_q
);

    logic [NCELL-1:0] grp_mask;
    logic [NCELL-1:0] grp_data;

    always_comb begin
        grp_mask = parity_mask(ctl.grp.parity);
        grp_data = spread(pl_data, ctl.grp.parity);
    end

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        logic hit1;
        logic hit2;

        always_comb begin
            hit1 = grp_mask[c] && (ctl.grp.rank == RANK_ONE);
            hit2 = grp_mask[c] && (ctl.grp.rank == RANK_TWO);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                rank1_q[c] <= 1'b0;
                rank2_q[c] <= 1'b0;
            end else if (ctl.load) begin
                if (hit1) rank1_q[c] <= grp_data[c];
                if (hit2) rank2_q[c] <= grp_data[c];
            end else if (ctl.capture) begin
                rank1_q[c] <= d_rank1[c];
                rank2_q[c] <= d_rank2[c];
            end
        end
    end

    // R1: reset clears the whole bank
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (rank1_q == '0 && rank2_q == '0));

    // R3, R4: loaded group matches the pin bus in cell order
    a_r3_group_loaded: assert property (@(posedge clk) disable iff (rst)
        (ctl.load && ctl.grp.rank == RANK_ONE) |=>
            gather(rank1_q, $past(ctl.grp.parity)) == $past(pl_data));

    // R6: loading one rank leaves the other rank untouched
    a_r6_other_rank_hold: assert property (@(posedge clk) disable iff (rst)
        (ctl.load && ctl.grp.rank == RANK_ONE) |=> $stable(rank2_q));

    // R2: no capture and no load means the bank holds
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.capture) |=> ($stable(rank1_q) && $stable(rank2_q)));

endmodule

// File: rtl/tap_out_mux.sv
module tap_out_mux #(
    parameter int NCELL = tap_pkg::CELL_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             obs_on,
    input  logic             lock,
    input  logic [NCELL-1:0] out_d,
    input  logic [NCELL-1:0] pin_oe,
    input  logic [NCELL-1:0] rank2_q,
    output logic [NCELL-1:0] pin_q
);

    for (genvar c = 0; c < NCELL; c++) begin : g_pin
        logic src;
        always_comb begin
            src      = obs_on ? rank2_q[c] : out_d[c];
            pin_q[c] = pin_oe[c] && src;
        end
    end

    // R8: a disabled output never drives a one
    a_r8_oe_gate: assert property (@(posedge clk) disable iff (rst)
        (pin_q & ~pin_oe) == '0);

    // R9: under lock the outputs carry normal data only
    a_r9_lock_normal_out: assert property (@(posedge clk) disable iff (rst)
        lock |-> pin_q == (out_d & pin_oe));

endmodule

// File: rtl/reg_test_access.sv
module reg_test_access
    import tap_pkg::*;
#(
    parameter int NCELL = tap_pkg::CELL_N,
    localparam int GW   = NCELL / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [NCELL-1:0] d_rank1,
    input  logic [NCELL-1:0] d_rank2,
    input  logic [NCELL-1:0] out_d,
    input  logic [NCELL-1:0] pin_oe,
    input  logic             pl_mode,
    input  logic             obs_mode,
    input  logic             lock,
    input  logic             tst_stb,
    input  logic             rank_sel,
    input  logic             odd_sel,
    input  logic [GW-1:0]    pl_data,
    output logic [NCELL-1:0] rank1_q,
    output logic [NCELL-1:0] rank2_q,
    output logic [NCELL-1:0] pin_q
);

    bank_ctl_t ctl;
    logic      obs_on;

    tap_mode_dec u_dec (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .pl_mode  (pl_mode),
        .obs_mode (obs_mode),
        .lock     (lock),
        .tst_stb  (tst_stb),
        .rank_sel (rank_sel),
        .odd_sel  (odd_sel),
        .ctl      (ctl),
        .obs_on   (obs_on)
    );

    tap_cell_bank #(.NCELL(NCELL)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .d_rank1 (d_rank1),
        .d_rank2 (d_rank2),
        .pl_data (pl_data),
        .rank1_q (rank1_q),
        .rank2_q (rank2_q)
    );

    tap_out_mux #(.NCELL(NCELL)) u_mux (
        .clk     (clk),
        .rst     (rst),
        .obs_on  (obs_on),
        .lock    (lock),
        .out_d   (out_d),
        .pin_oe  (pin_oe),
        .rank2_q (rank2_q),
        .pin_q   (pin_q)
    );

    // R10: with both modes on, the outputs follow the second rank
    a_r10_obs_during_load: assert property (@(posedge clk) disable iff (rst)
        (pl_mode && obs_mode && !lock) |-> pin_q == (rank2_q & pin_oe));

endmodule

// File: tb/reg_test_access_bench.sv
module reg_test_access_bench;

    localparam int N  = 24;
    localparam int GW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cap_en = 1'b0;
    logic [N-1:0]  d_rank1 = '0, d_rank2 = '0, out_d = '0, pin_oe = '0;
    logic          pl_mode = 1'b0, obs_mode = 1'b0, lock = 1'b0, tst_stb = 1'b0;
    logic          rank_sel = 1'b0, odd_sel = 1'b0;
    logic [GW-1:0] pl_data = '0;
    logic [N-1:0]  rank1_q, rank2_q, pin_q;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk;

    reg_test_access u_reg_test_access (
        .clk(clk), .rst(rst), .cap_en(cap_en),
        .d_rank1(d_rank1), .d_rank2(d_rank2), .out_d(out_d), .pin_oe(pin_oe),
        .pl_mode(pl_mode), .obs_mode(obs_mode), .lock(lock), .tst_stb(tst_stb),
        .rank_sel(rank_sel), .odd_sel(odd_sel), .pl_data(pl_data),
        .rank1_q(rank1_q), .rank2_q(rank2_q), .pin_q(pin_q)
    );

    // Behavioural reference: two bit arrays and the previous strobe level.
    bit    m1 [N];
    bit    m2 [N];
    bit    stb_prev;
    string tag = "R1";

    always @(posedge clk) begin
        if (rst) begin
            foreach (m1[k]) begin m1[k] = 1'b0; m2[k] = 1'b0; end
            stb_prev = 1'b0;
            tag = "R1";
        end else begin
            if (tst_stb && !stb_prev && pl_mode && !lock) begin
                for (int i = 0; i < GW; i++) begin
                    if (rank_sel) m2[2*i + int'(odd_sel)] = pl_data[i];
                    else          m1[2*i + int'(odd_sel)] = pl_data[i];
                end
                tag = obs_mode ? "R10" : "R3";
            end else begin
                if (cap_en) begin
                    for (int k = 0; k < N; k++) begin
                        m1[k] = d_rank1[k];
                        m2[k] = d_rank2[k];
                    end
                end
                tag = lock ? "R9" : (tst_stb && pl_mode) ? "R7" : "R2";
            end
            stb_prev = tst_stb;
        end
        #8;
        compare();
    end

    task automatic compare();
        logic [N-1:0] e1, e2, ep;
        for (int k = 0; k < N; k++) begin
            e1[k] = m1[k];
            e2[k] = m2[k];
        end
        ep = pin_oe & ((obs_mode && !lock) ? e2 : out_d);
        vectors++;
        if (rank1_q !== e1) begin
            errors++;
            $display("FAIL %s rank1_q actual %h expected %h", tag, rank1_q, e1);
        end
        if (rank2_q !== e2) begin
            errors++;
            $display("FAIL %s rank2_q actual %h expected %h", tag, rank2_q, e2);
        end
        if (pin_q !== ep) begin
            errors++;
            $display("FAIL R8 pin_q actual %h expected %h", pin_q, ep);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rnd_data();
        d_rank1 = N'($urandom);
        d_rank2 = N'($urandom);
        out_d   = N'($urandom);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R1: reset with nonzero data applied
        rnd_data();
        cap_en = 1'b1;
        cycles(3);
        rst = 1'b0;
        // R2: normal capture
        for (int j = 0; j < 6; j++) begin
            rnd_data();
            pin_oe = N'($urandom);
            cycles(1);
        end
        cap_en = 1'b0;
        cycles(2);
        // R3, R4, R5, R6, R7: every group, capture active on the strobe edge
        pl_mode = 1'b1;
        for (int g = 0; g < 4; g++) begin
            rank_sel = g[0];
            odd_sel  = g[1];
            cap_en   = 1'b1;
            pl_data  = GW'($urandom);
            rnd_data();
            cycles(1);
            tst_stb = 1'b1;
            rnd_data();
            cycles(1);
            tst_stb = 1'b1;
            cap_en = 1'b0;
            pl_data = ~pl_data;
            cycles(3);
            tst_stb = 1'b0;
            cycles(1);
        end
        // R7: strobe edge with preload mode off loads nothing
        pl_mode = 1'b0;
        pl_data = 12'hA5C;
        tst_stb = 1'b1;
        cycles(1);
        tst_stb = 1'b0;
        cycles(1);
        // R8: observe with random enables
        obs_mode = 1'b1;
        for (int j = 0; j < 5; j++) begin
            pin_oe = N'($urandom);
            out_d  = N'($urandom);
            cycles(1);
        end
        // R10: both modes together
        pl_mode  = 1'b1;
        rank_sel = 1'b1;
        odd_sel  = 1'b1;
        pl_data  = 12'h3C9;
        pin_oe   = '1;
        tst_stb  = 1'b1;
        cycles(2);
        tst_stb = 1'b0;
        cycles(1);
        // R9: lock inhibits both modes
        lock = 1'b1;
        cap_en = 1'b1;
        for (int j = 0; j < 4; j++) begin
            tst_stb = ~tst_stb;
            pl_data = GW'($urandom);
            rnd_data();
            cycles(1);
        end
        lock = 1'b0;
        tst_stb = 1'b0;
        cycles(1);
        // Random mix of all inputs
        for (int j = 0; j < 400; j++) begin
            cap_en   = 1'($urandom);
            pl_mode  = ($urandom % 4) != 0;
            obs_mode = 1'($urandom);
            lock     = ($urandom % 6) == 0;
            tst_stb  = 1'($urandom);
            rank_sel = 1'($urandom);
            odd_sel  = 1'($urandom);
            pl_data  = GW'($urandom);
            pin_oe   = N'($urandom);
            rnd_data();
            if (j == 300) rst = 1'b1;
            if (j == 302) rst = 1'b0;
            cycles(1);
        end
        cycles(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule